// File: doc/BRIEF.md
# General-Purpose Register File with Same-Cycle Forwarding

This block is the architected register store of an in-order pipeline. It holds a parameterised set of general-purpose registers, 32 registers of 32 bits by default. It has two independent combinational read ports that serve the decode stage and one write port that the write-back stage drives on the rising clock edge.

A pipeline often writes back a register in the same cycle that a younger instruction reads it in decode. In that case the read port returns the data being written instead of the stale stored value. This gives the effect of a write in the first half of the cycle followed by a read in the second half, while using only one clock edge, so decode does not stall behind write-back.

Register 0 is a constant zero. Writes aimed at it are dropped, and it never takes part in forwarding. An asynchronous active-low reset clears every register.

Top module: `gprf_bypass`

## Requirements
- R1: With `wr_en` high at a rising clock edge, `wr_data` is stored in register `wr_addr` (1..31). From the next cycle, either read port addressing that register returns the value.
- R2: A read port whose address is 0 returns 32'h0 in every cycle.
- R3: A write with `wr_addr` = 0 is discarded and is never forwarded. Register 0 still reads 0 in the same cycle and in every later cycle.
- R4: When `wr_en` is high and `wr_addr` (non-zero) equals a read port's address in the same cycle, that port returns `wr_data` combinationally, before the edge that commits the write.
- R5: When `wr_en` is low, no register changes and no forwarding happens, even if `wr_addr` matches a read address. The read returns the stored value.
- R6: While `rst_n` is low, every register is cleared to zero immediately (asynchronous reset), and it stays zero after release until written.
- R7: The two read ports are independent. Different addresses on the two ports return their own registers in the same cycle, and forwarding on one port does not alter the other.
- R8: Successive writes to one register keep only the most recent value. A write that overlaps a read of the same register forwards the new value, not the earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | 5 | Register index written |
| wr_data | input | 32 | Data written |
| rd_a_addr | input | 5 | Register index for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_addr | input | 5 | Register index for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |

## Verification
On every cycle the assertions check the following: address 0 yields zero on both ports, forwarding is never flagged for address 0 or with the write enable low, a matching enabled write appears on the port at once, a committed write is visible one cycle later, and the ports read zero right after reset. Only the bench scenarios can show the full behaviour of the store. That covers a sweep writing and reading back all 31 writable registers through both ports, overwrite ordering, the asynchronous clear in the middle of a run, and the proof that a disabled or register-0 write left the stored contents untouched.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

  // Forwarding condition shared by every read port: an enabled write to
  // the same non-zero register as the read.
  function automatic logic same_cycle_fwd(input logic we,
                                          input int unsigned wa,
                                          input int unsigned ra);
    return we && (wa == ra) && (ra != 0);
  endfunction

  // True when an index addresses a writable register.
  function automatic logic writable_index(input int unsigned idx,
                                          input int unsigned nregs);
    return (idx != 0) && (idx < nregs);
  endfunction

endpackage

// File: rtl/gprf_write_ctl.sv
module gprf_write_ctl #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_REGS-1:1] row_sel
);
  import gprf_pkg::*;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_sel
    assign row_sel[i] = wr_en && (int'(wr_addr) == i) &&
                        writable_index(i, NUM_REGS);
  end
endmodule

// File: rtl/gprf_storage.sv
module gprf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:1]              row_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  rows
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_row
    if (i == 0) begin : g_const
      assign rows[i] = '0;
    end else begin : g_flop
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (row_sel[i]) q <= wr_data;
      end
      assign rows[i] = q;
    end
  end
endmodule

// File: rtl/gprf_read_port.sv
module gprf_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] rows,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            fwd_hit
);
  import gprf_pkg::*;

  logic [DATA_W-1:0] stored;

  assign fwd_hit = same_cycle_fwd(wr_en, int'(wr_addr), int'(rd_addr));

  always_comb begin
    stored = '0;
    if (int'(rd_addr) < NUM_REGS) stored = rows[rd_addr];
  end

  always_comb begin
    if (rd_addr == '0)  rd_data = '0;
    else if (fwd_hit)   rd_data = wr_data;
    else                rd_data = stored;
  end
endmodule

// File: rtl/gprf_bypass.sv
module gprf_bypass #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:1]             row_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] rows;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;
  logic [NUM_RD-1:0]               fwd_hit_v;

  // Named events for the checker
  logic fwd_a, fwd_b;

  assign rd_addr_v[0] = rd_a_addr;
  assign rd_addr_v[1] = rd_b_addr;
  assign rd_a_data    = rd_data_v[0];
  assign rd_b_data    = rd_data_v[1];
  assign fwd_a        = fwd_hit_v[0];
  assign fwd_b        = fwd_hit_v[1];

  gprf_write_ctl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_wctl (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .row_sel (row_sel)
  );

  gprf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_sel (row_sel),
    .wr_data (wr_data),
    .rows    (rows)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gprf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
      .rows    (rows),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr_v[p]),
      .rd_data (rd_data_v[p]),
      .fwd_hit (fwd_hit_v[p])
    );
  end
endmodule

// File: rtl/gprf_bypass_checker.sv
module gprf_bypass_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              fwd_a,
  input logic              fwd_b
);
  // R2
  a_r2_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0));
  a_r2_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == '0) |-> (rd_b_data == '0));

  // R3
  a_r3_no_fwd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_a_addr == '0) |-> !fwd_a) and ((rd_b_addr == '0) |-> !fwd_b));

  // R4
  a_r4_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_a_addr && rd_a_addr != '0) |-> (rd_a_data == wr_data));
  a_r4_fwd_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_b_addr && rd_b_addr != '0) |-> (rd_b_data == wr_data));

  // R5
  a_r5_idle_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (!fwd_a && !fwd_b));

  // R1
  a_r1_commit_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_addr) != '0 &&
     rd_a_addr == $past(wr_addr) && !(wr_en && wr_addr == rd_a_addr))
    |-> (rd_a_data == $past(wr_data)));

  // R6
  a_r6_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !fwd_a && !fwd_b) |-> (rd_a_data == '0 && rd_b_data == '0));
endmodule

bind gprf_bypass gprf_bypass_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_a_addr (rd_a_addr),
  .rd_a_data (rd_a_data),
  .rd_b_addr (rd_b_addr),
  .rd_b_data (rd_b_data),
  .fwd_a     (fwd_a),
  .fwd_b     (fwd_b)
);

// File: tb/gprf_bypass_test.sv
module gprf_bypass_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_a_addr = '0;
  logic [4:0]  rd_b_addr = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [32];

  gprf_bypass uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] pattern(input int i);
    return (32'hC3000000 | (i << 8) | i) ^ (i * 32'h00100001);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply inputs on the falling edge and settle before sampling.
  task automatic apply(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_a_addr = ra; rd_b_addr = rb;
    #1;
  endtask

  // Let the applied write commit at the next rising edge, update the model.
  task automatic commit();
    @(posedge clk);
    if (wr_en && wr_addr != 0) model[wr_addr] = wr_data;
  endtask

  task automatic idle();
    apply(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 32; i++) begin
      apply(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
      check("R6 reset A", rd_a_data, 32'h0);
      check("R6 reset B", rd_b_data, 32'h0);
    end
  endtask

  task automatic t_fill_and_read();
    for (int i = 1; i < 32; i++) begin
      apply(1'b1, 5'(i), pattern(i), 5'd0, 5'd0);
      commit();
    end
    idle();
    for (int i = 1; i < 32; i++) begin
      apply(1'b0, 5'd0, 32'h0, 5'(i), 5'(32 - i));
      check("R1 readback A", rd_a_data, model[i]);
      check("R7 independent B", rd_b_data, model[32 - i]);
    end
  endtask

  task automatic t_reg_zero();
    apply(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    check("R3 no forward A", rd_a_data, 32'h0);
    check("R2 zero B", rd_b_data, 32'h0);
    commit();
    apply(1'b0, 5'd0, 32'h0, 5'd0, 5'd1);
    check("R3 discarded", rd_a_data, 32'h0);
    check("R3 r1 untouched", rd_b_data, model[1]);
  endtask

  task automatic t_forward();
    apply(1'b1, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd5);
    check("R4 forward A", rd_a_data, 32'hDEAD_BEEF);
    check("R4 forward B", rd_b_data, 32'hDEAD_BEEF);
    commit();
    apply(1'b1, 5'd6, 32'h1234_5678, 5'd5, 5'd6);
    check("R1 committed A", rd_a_data, 32'hDEAD_BEEF);
    check("R4 forward B only", rd_b_data, 32'h1234_5678);
    commit();
    apply(1'b1, 5'd9, 32'h0BAD_F00D, 5'd9, 5'd10);
    check("R4 forward A", rd_a_data, 32'h0BAD_F00D);
    check("R7 B unaffected", rd_b_data, model[10]);
    commit();
    apply(1'b0, 5'd0, 32'h0, 5'd9, 5'd6);
    check("R1 stored 9", rd_a_data, 32'h0BAD_F00D);
    check("R1 stored 6", rd_b_data, 32'h1234_5678);
  endtask

  task automatic t_disabled();
    logic [31:0] old7;
    old7 = model[7];
    apply(1'b0, 5'd7, 32'hAAAA_5555, 5'd7, 5'd7);
    check("R5 no forward A", rd_a_data, old7);
    check("R5 no forward B", rd_b_data, old7);
    commit();
    apply(1'b0, 5'd0, 32'h0, 5'd7, 5'd0);
    check("R5 no write", rd_a_data, old7);
  endtask

  task automatic t_overwrite();
    apply(1'b1, 5'd12, 32'h1111_1111, 5'd0, 5'd0);
    commit();
    apply(1'b1, 5'd12, 32'h2222_2222, 5'd12, 5'd0);
    check("R8 newest forwarded", rd_a_data, 32'h2222_2222);
    commit();
    apply(1'b0, 5'd0, 32'h0, 5'd0, 5'd12);
    check("R8 last wins", rd_b_data, 32'h2222_2222);
  endtask

  task automatic t_mid_reset();
    apply(1'b0, 5'd0, 32'h0, 5'd12, 5'd31);
    rst_n = 1'b0;
    #1;
    check("R6 async clear A", rd_a_data, 32'h0);
    check("R6 async clear B", rd_b_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) model[i] = '0;
    t_reset_state();
  endtask

  initial begin
    #(20 * 50000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R6 during reset", rd_a_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_fill_and_read();
    t_reg_zero();
    t_forward();
    t_disabled();
    t_overwrite();
    t_mid_reset();
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule